// File: doc/BRIEF.md
# PC-Relative Address Generator

This block forms the addresses for operations that reference code or data relative to the program counter. It is purely combinational: a mode select chooses one of three address forms, and the 32-bit result appears in the same cycle as its operands. There is no clock and no state. A decode stage supplies the current PC, a 21-bit immediate field, a base register value and the mode code. The address goes on to a load/store unit, a jump target, or a register write.

Two routes cover the full 32-bit space.

- **Two-step route.** A high-part operation adds the immediate, shifted up by 11 bits, to the PC. A following low-part operation adds a sign-extended 11-bit offset to that register value.
- **One-step route.** This is for jumps, calls, word loads, word stores and address-add that use the PC as base. It scales a signed 21-bit offset by four, which reaches about ±4 MB around the PC.

A PC whose low two bits are not zero raises an alignment flag in the one-step route.

Top module: `pcrel_agen`

## Requirements
- R1: With mode code 0 (high part), `addr_o` equals `pc_i + (imm_i << 11)` truncated to 32 bits.
- R2: In mode 0 and in mode 2, `base_i` has no effect on `addr_o` or `misalign_o`.
- R3: With mode code 1 (low part), `addr_o` equals `base_i` plus `imm_i[10:0]` sign-extended from bit 10. `pc_i` and `imm_i[20:11]` have no effect.
- R4: Take a mode-0 operation at PC value P with immediate H, whose result is used as `base_i` of a mode-1 operation at PC P+4 with immediate L. For any 32-bit target T, the pair yields T when:
  - L is the low 11 bits of T−P;
  - H is (T−P − sext(L)) >> 11.
- R5: With mode code 2 (near), `addr_o` equals `pc_i` plus `imm_i` sign-extended from bit 20 and multiplied by four, truncated to 32 bits.
- R6: The near result wraps modulo 2^32 at both ends of the range.
  - PC 0x00000000 with offset field 0x100000 gives 0xFFC00000.
  - PC 0xFFFFFFFC with offset field 0x0FFFFF gives 0x003FFFF8.
- R7: In mode 2, `misalign_o` is 1 exactly when `pc_i[1:0]` is nonzero. The address is still formed, and `addr_o[1:0]` equals `pc_i[1:0]`.
- R8: `misalign_o` is 0 in every mode other than 2.
- R9: Mode code 3 is reserved. It gives `addr_o` = 0 and `misalign_o` = 0.
- R10: The output follows the inputs within the same cycle, with no register stage. With all inputs zero, `addr_o` is 0 and `misalign_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Program counter of the current operation |
| imm_i | input | 21 | Immediate field; all bits in modes 0 and 2, bits 10:0 in mode 1 |
| base_i | input | 32 | Register value holding a previously formed high part |
| mode_i | input | 2 | 0 high part, 1 low part, 2 near, 3 reserved |
| addr_o | output | 32 | Generated address |
| misalign_o | output | 1 | Near-mode PC not word aligned |

## Verification
In near mode, the alignment flag and the address are produced in the same cycle from the same PC. A misaligned PC must raise the flag while the sum is still delivered with its low bits carried through. The bench provokes this by sweeping all four values of the PC's low two bits against sweeps of positive, negative and limit offsets. It judges each vector on both outputs together: the flag against the PC bits, and the address against a signed product computed in the bench.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

    localparam int ADDR_W  = 32;
    localparam int IMM_W   = 21;
    localparam int LO_W    = 11;
    localparam int NEAR_SH = 2;
    localparam int HI_SH   = ADDR_W - IMM_W;

    typedef enum logic [1:0] {
        PCR_HI   = 2'd0,
        PCR_LO   = 2'd1,
        PCR_NEAR = 2'd2,
        PCR_RSV  = 2'd3
    } pcr_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              misalign;
    } pcr_res_t;

    function automatic logic [ADDR_W-1:0] sext_lo(input logic [LO_W-1:0] v);
        return {{(ADDR_W-LO_W){v[LO_W-1]}}, v};
    endfunction

    function automatic logic [ADDR_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(ADDR_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/pcrel_hi_gen.sv
module pcrel_hi_gen
    import pcrel_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = IMM_W
) (
    input  logic [AW-1:0] pc,
    input  logic [IW-1:0] imm,
    output pcr_res_t      res
);
    localparam int SH = AW - IW;

    logic [AW-1:0] upper;

    generate
        if (SH > 0) begin : g_pad
            assign upper = {imm, {SH{1'b0}}};
        end else begin : g_nopad
            assign upper = imm[AW-1:0];
        end
    endgenerate

    always_comb begin
        res.addr     = pc + upper;
        res.misalign = 1'b0;
    end
endmodule

// File: rtl/pcrel_lo_gen.sv
module pcrel_lo_gen
    import pcrel_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LO_W
) (
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] lo,
    output pcr_res_t      res
);
    logic [AW-1:0] lo_ext;

    assign lo_ext = {{(AW-LW){lo[LW-1]}}, lo};

    always_comb begin
        res.addr     = base + lo_ext;
        res.misalign = 1'b0;
    end
endmodule

// File: rtl/pcrel_near_gen.sv
module pcrel_near_gen
    import pcrel_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = IMM_W,
    parameter int SH = NEAR_SH
) (
    input  logic [AW-1:0] pc,
    input  logic [IW-1:0] imm,
    output pcr_res_t      res
);
    localparam int EXT = AW - IW - SH;

    logic [AW-1:0] offset;

    generate
        if (EXT > 0) begin : g_ext
            assign offset = {{EXT{imm[IW-1]}}, imm, {SH{1'b0}}};
        end else begin : g_trunc
            logic [IW+SH-1:0] wide;
            assign wide   = {imm, {SH{1'b0}}};
            assign offset = wide[AW-1:0];
        end
    endgenerate

    always_comb begin
        res.addr     = pc + offset;
        res.misalign = |pc[SH-1:0];
    end
endmodule

// File: rtl/pcrel_agen.sv
module pcrel_agen
    import pcrel_pkg::*;
(
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              misalign_o
);
    pcr_res_t  hi_res, lo_res, near_res, sel_res;
    pcr_mode_e mode;

    assign mode = pcr_mode_e'(mode_i);

    pcrel_hi_gen #(.AW(ADDR_W), .IW(IMM_W)) u_hi (
        .pc  (pc_i),
        .imm (imm_i),
        .res (hi_res)
    );

    pcrel_lo_gen #(.AW(ADDR_W), .LW(LO_W)) u_lo (
        .base (base_i),
        .lo   (imm_i[LO_W-1:0]),
        .res  (lo_res)
    );

    pcrel_near_gen #(.AW(ADDR_W), .IW(IMM_W), .SH(NEAR_SH)) u_near (
        .pc  (pc_i),
        .imm (imm_i),
        .res (near_res)
    );

    always_comb begin
        unique case (mode)
            PCR_HI:   sel_res = hi_res;
            PCR_LO:   sel_res = lo_res;
            PCR_NEAR: sel_res = near_res;
            default:  sel_res = '0;
        endcase
    end

    assign addr_o     = sel_res.addr;
    assign misalign_o = sel_res.misalign;
endmodule

// File: rtl/pcrel_agen_chk.sv
module pcrel_agen_chk
    import pcrel_pkg::*;
(
    input logic [LO_W-1:0]   pc_lo,
    input logic [LO_W-1:0]   imm_lo,
    input logic [LO_W-1:0]   base_lo,
    input logic [1:0]        mode_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              misalign_o
);
    logic [LO_W-1:0] lo_sum;

    always_comb begin
        lo_sum = base_lo + imm_lo;
        // R1
        hi_low_bits_chk: assert (mode_i != 2'd0 || addr_o[LO_W-1:0] == pc_lo);
        // R3
        lo_low_bits_chk: assert (mode_i != 2'd1 || addr_o[LO_W-1:0] == lo_sum);
        // R7
        near_align_chk: assert (mode_i != 2'd2 || (addr_o[1:0] == pc_lo[1:0] && misalign_o == (pc_lo[1:0] != 2'b00)));
        // R8
        misalign_mode_chk: assert (!misalign_o || mode_i == 2'd2);
        // R9
        rsv_zero_chk: assert (mode_i != 2'd3 || (addr_o == '0 && !misalign_o));
    end
endmodule

bind pcrel_agen pcrel_agen_chk u_chk (
    .pc_lo      (pc_i[pcrel_pkg::LO_W-1:0]),
    .imm_lo     (imm_i[pcrel_pkg::LO_W-1:0]),
    .base_lo    (base_i[pcrel_pkg::LO_W-1:0]),
    .mode_i     (mode_i),
    .addr_o     (addr_o),
    .misalign_o (misalign_o)
);

// File: tb/sim_pcrel_agen.sv
module sim_pcrel_agen;
    logic        clk = 1'b0;
    logic [31:0] pc, base;
    logic [20:0] imm;
    logic [1:0]  mode;
    logic [31:0] addr;
    logic        mis;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    logic [31:0] lfsr   = 32'h1234_5679;

    always #10 clk = ~clk;

    pcrel_agen u0 (
        .pc_i(pc), .imm_i(imm), .base_i(base), .mode_i(mode),
        .addr_o(addr), .misalign_o(mis)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [31:0] p, input logic [20:0] i,
                         input logic [31:0] b);
        @(posedge clk);
        mode = m; pc = p; imm = i; base = b;
        @(negedge clk);
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    function automatic logic [31:0] near_exp(input logic [31:0] p, input logic [20:0] i);
        int off;
        off = i[20] ? int'(i) - (1 << 21) : int'(i);
        return p + 32'(off * 4);
    endfunction

    function automatic logic [31:0] lo_ext(input logic [10:0] l);
        int v;
        v = l[10] ? int'(l) - 2048 : int'(l);
        return 32'(v);
    endfunction

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        pc = '0; imm = '0; base = '0; mode = 2'd0;
        @(negedge clk);
        // R10 zero inputs
        chk("R10 addr", addr, 32'h0);
        chk("R10 mis", {31'b0, mis}, 32'h0);

        // R1, R2: high part sweep, base randomised
        for (int k = 0; k < 4096; k++) begin
            logic [31:0] p, b;
            logic [20:0] i;
            p = rnd(); b = rnd();
            i = (k < 8) ? 21'((k[0] ? 21'h1FFFFF : 21'h0) ^ (21'h1 << k)) : rnd()[20:0];
            drive(2'd0, p, i, b);
            chk("R1 hi", addr, p + {i, 11'b0});
            chk("R8 hi mis", {31'b0, mis}, 32'h0);
            drive(2'd0, p, i, ~b);
            chk("R2 hi base ignored", addr, p + {i, 11'b0});
        end

        // R3: every low offset, pc and upper imm varied
        for (int l = 0; l < 2048; l++) begin
            logic [31:0] b;
            b = rnd();
            drive(2'd1, rnd(), {rnd()[9:0], 11'(l)}, b);
            chk("R3 lo", addr, b + lo_ext(11'(l)));
            chk("R8 lo mis", {31'b0, mis}, 32'h0);
        end

        // R4: hi/lo pairs reproduce arbitrary targets
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] p, t, off, hipart;
            logic [10:0] l;
            logic [20:0] h;
            p = (k < 4) ? 32'h0 : {rnd()[31:2], 2'b00};
            t = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0000_07FF :
                (k == 2) ? 32'h8000_0800 : rnd();
            off = t - p;
            l = off[10:0];
            h = 21'((off - lo_ext(l)) >> 11);
            drive(2'd0, p, h, rnd());
            hipart = addr;
            drive(2'd1, p + 32'd4, {10'h155, l}, hipart);
            chk("R4 pair", addr, t);
        end

        // R5, R7, R2: near mode across offsets and all pc low-bit values
        for (int k = 0; k < 6000; k++) begin
            logic [31:0] p, b;
            logic [20:0] i;
            p = rnd(); b = rnd();
            i = (k % 3 == 0) ? 21'h0FFFFF : (k % 3 == 1) ? 21'h100000 : rnd()[20:0];
            if (k % 5 == 0) i = rnd()[20:0];
            drive(2'd2, p, i, b);
            chk("R5 near", addr, near_exp(p, i));
            chk("R7 mis", {31'b0, mis}, {31'b0, p[1:0] != 2'b00});
            drive(2'd2, p, i, ~b);
            chk("R2 near base ignored", addr, near_exp(p, i));
        end

        // R6: wraparound at both limits
        drive(2'd2, 32'h0000_0000, 21'h100000, 32'h0);
        chk("R6 low wrap", addr, 32'hFFC0_0000);
        drive(2'd2, 32'hFFFF_FFFC, 21'h0FFFFF, 32'h0);
        chk("R6 high wrap", addr, 32'h003F_FFF8);
        drive(2'd2, 32'h0000_0004, 21'h1FFFFE, 32'h0);
        chk("R6 small wrap", addr, 32'hFFFF_FFFC);

        // R9: reserved code
        for (int k = 0; k < 64; k++) begin
            drive(2'd3, rnd() | 32'h3, rnd()[20:0], rnd());
            chk("R9 addr", addr, 32'h0);
            chk("R9 mis", {31'b0, mis}, 32'h0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule